// File: doc/BRIEF.md
# Synchronous Rectifier Gate Drive Sequencer

This block drives the two gates of the synchronous rectifier on the secondary side of a push-pull converter. It keeps both gates in step with the primary-side switches. The primary PWM generator supplies its two gate signals and a start-of-cycle strobe. The primary works in push-pull fashion, so the strobe fires twice in every primary period. Each strobe restarts a local secondary timer. That timer opens a conduction window after a programmable turn-on delay, and the window lasts for a programmable number of clocks. While the delay runs, the rectifier body diode carries the current.

The conduction windows alternate between a high phase and a low phase, one per strobe. Each window is ANDed with the primary gate of the same phase and then routed to the opposite secondary pin. This routing has three effects. A primary pulse cut short by current limiting ends its secondary pulse at the same time. A window that opens while its primary switch is off produces no pulse. The secondary gate never conducts unless its primary partner conducts. Both gate outputs are registered.

Top module: `sr_gate`

## Requirements
- R1: A synchronous reset drives both gate outputs low. It also selects the high phase for the next window. After reset, both outputs stay low until the first start-of-cycle strobe arrives, whatever the primary gates do.
- R2: Every start-of-cycle strobe restarts the secondary timer at zero, including a strobe that arrives in the middle of an open window.
- R3: With a latched delay D, the clock edge that samples the strobe is edge 0. A gate can first be high after edge D+1, so D clocks pass before any conduction.
- R4: With a latched on-time T, a gate can be high only after edges D+1 through D+T. T = 0 gives no pulse.
- R5: The first strobe after reset opens a high-phase window. Each later strobe switches to the other phase, so the phases run high, low, high, and so on. The two gates are never high together.
- R6: The `sec_lo_gate` output is the registered AND of `pri_hi` and the high-phase window. It goes high one clock after both are true.
- R7: The `sec_hi_gate` output is the registered AND of `pri_lo` and the low-phase window.
- R8: When the matching primary gate falls inside an open window, the secondary gate falls at the next clock edge. This truncation follows the primary pulse.
- R9: A window whose matching primary gate stays low for its whole length produces no secondary pulse.
- R10: `cfg_delay` and `cfg_ontime` are sampled only on a strobe. A change at any other time has no effect on the window that is already running.
- R11: In the clock that samples a strobe, both gate outputs are forced low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the primary gates are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| soc | input | 1 | Start-of-cycle strobe from the primary generator, one clock wide |
| pri_hi | input | 1 | Primary high-side gate |
| pri_lo | input | 1 | Primary low-side gate |
| cfg_delay | input | CNT_W | Turn-on delay, in clocks |
| cfg_ontime | input | CNT_W | Maximum on-time, in clocks |
| sec_hi_gate | output | 1 | Secondary high-pin gate, driven from the low phase |
| sec_lo_gate | output | 1 | Secondary low-pin gate, driven from the high phase |

## Verification
The bench fires a strobe in the middle of an open window. A timer that fails to restart would keep its old window open, or would open the new one too early. The bench also changes the configuration while a window runs. A design that picks up values outside a strobe would visibly shift the pulse edges. The zero-delay and zero-on-time corners catch off-by-one window compares. Dropping a primary gate mid-pulse, or holding it low for a whole window, exposes missing truncation or suppression. A reset in the middle of the sequence must send the next window back to the high phase. A design that keeps the alternation through reset would drive the wrong pin.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } sr_phase_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } sr_pair_t;

    function automatic sr_phase_e sr_flip(input sr_phase_e p);
        return (p == PH_HI) ? PH_LO : PH_HI;
    endfunction

endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soc,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_ontime,
    output logic             win
);
    localparam int LIM_W = CNT_W + 1;

    logic [LIM_W-1:0] cnt;
    logic [CNT_W-1:0] dly_q;
    logic [CNT_W-1:0] ont_q;
    logic             active;
    logic [LIM_W-1:0] lim;

    assign lim = {1'b0, dly_q} + {1'b0, ont_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dly_q  <= '0;
            ont_q  <= '0;
            active <= 1'b0;
        end else if (soc) begin
            cnt    <= '0;
            dly_q  <= cfg_delay;
            ont_q  <= cfg_ontime;
            active <= 1'b1;
        end else if (active && (cnt != lim)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign win = active && (cnt >= {1'b0, dly_q}) && (cnt < lim);

    // R2: a strobe restarts the count
    a_r2_restart_zero: assert property (@(posedge clk) disable iff (rst)
        soc |=> (cnt == '0));

    // R4: the count saturates at the window end
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim);

    // R10: latched settings hold between strobes
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !soc |=> ($stable(dly_q) && $stable(ont_q)));

endmodule

// File: rtl/sr_phase_sel.sv
module sr_phase_sel
    import sr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      soc,
    input  logic      win,
    output sr_pair_t  raw
);
    sr_phase_e cur_ph;
    sr_phase_e nxt_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ph <= PH_HI;
            nxt_ph <= PH_HI;
        end else if (soc) begin
            cur_ph <= nxt_ph;
            nxt_ph <= sr_flip(nxt_ph);
        end
    end

    assign raw.hi = win && (cur_ph == PH_HI);
    assign raw.lo = win && (cur_ph == PH_LO);

    // R5: successive strobes select alternating phases
    a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
        soc |=> (cur_ph != nxt_ph));

endmodule

// File: rtl/sr_out_gate.sv
module sr_out_gate
    import sr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     soc,
    input  sr_pair_t pri,
    input  sr_pair_t raw,
    output sr_pair_t pin
);
    logic [1:0] pri_v;
    logic [1:0] raw_v;
    logic [1:0] pin_q;

    assign pri_v = {pri.lo, pri.hi};
    assign raw_v = {raw.lo, raw.hi};

    // channel i (0 = high phase, 1 = low phase) drives the opposite pin
    for (genvar i = 0; i < 2; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) pin_q[1-i] <= 1'b0;
            else     pin_q[1-i] <= !soc && pri_v[i] && raw_v[i];
        end
    end

    assign pin.hi = pin_q[0];
    assign pin.lo = pin_q[1];

    // R6: low pin only follows an active primary high gate
    a_r6_lo_needs_prihi: assert property (@(posedge clk) disable iff (rst)
        pin.lo |-> $past(pri.hi));

    // R7: high pin only follows an active primary low gate
    a_r7_hi_needs_prilo: assert property (@(posedge clk) disable iff (rst)
        pin.hi |-> $past(pri.lo));

    // R11: a strobe forces both gates low
    a_r11_soc_blank: assert property (@(posedge clk) disable iff (rst)
        soc |=> (!pin.hi && !pin.lo));

    // R5: never both gates on
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pin.hi, pin.lo}));

    // R1: reset clears the gates
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (!pin.hi && !pin.lo));

endmodule

// File: rtl/sr_gate.sv
module sr_gate
    import sr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soc,
    input  logic             pri_hi,
    input  logic             pri_lo,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_ontime,
    output logic             sec_hi_gate,
    output logic             sec_lo_gate
);
    logic     win;
    sr_pair_t raw;
    sr_pair_t pri;
    sr_pair_t pin;

    assign pri.hi = pri_hi;
    assign pri.lo = pri_lo;

    sr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .soc        (soc),
        .cfg_delay  (cfg_delay),
        .cfg_ontime (cfg_ontime),
        .win        (win)
    );

    sr_phase_sel u_phase (
        .clk (clk),
        .rst (rst),
        .soc (soc),
        .win (win),
        .raw (raw)
    );

    sr_out_gate u_out (
        .clk (clk),
        .rst (rst),
        .soc (soc),
        .pri (pri),
        .raw (raw),
        .pin (pin)
    );

    assign sec_hi_gate = pin.hi;
    assign sec_lo_gate = pin.lo;

endmodule

// File: tb/test_sr_gate.sv
module test_sr_gate;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             soc = 1'b0;
    logic             pri_hi = 1'b0;
    logic             pri_lo = 1'b0;
    logic [CNT_W-1:0] cfg_delay = '0;
    logic [CNT_W-1:0] cfg_ontime = '0;
    logic             sec_hi_gate;
    logic             sec_lo_gate;

    always #2.5 clk = ~clk;

    sr_gate #(.CNT_W(CNT_W)) i_sr_gate (
        .clk(clk), .rst(rst), .soc(soc), .pri_hi(pri_hi), .pri_lo(pri_lo),
        .cfg_delay(cfg_delay), .cfg_ontime(cfg_ontime),
        .sec_hi_gate(sec_hi_gate), .sec_lo_gate(sec_lo_gate)
    );

    typedef struct {
        logic  hi;
        logic  lo;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    // reference model state, built from the requirements
    bit m_active = 0;
    bit m_lo_ph  = 0;
    bit m_next   = 0;
    int m_cnt    = 0;
    int m_d      = 0;
    int m_t      = 0;

    task automatic monitor_pop();
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        n_checks++;
        if (sec_hi_gate !== e.hi || sec_lo_gate !== e.lo) begin
            n_errors++;
            $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b at %0t",
                     e.tag, sec_hi_gate, sec_lo_gate, e.hi, e.lo, $time);
        end
    endtask

    task automatic step(input bit r, input bit s, input bit ph, input bit pl,
                        input int d, input int t, input string tag);
        exp_t e;
        bit   in_win;
        @(negedge clk);
        monitor_pop();
        rst = r; soc = s; pri_hi = ph; pri_lo = pl;
        cfg_delay = CNT_W'(d); cfg_ontime = CNT_W'(t);
        in_win = m_active && (m_cnt >= m_d) && (m_cnt < m_d + m_t);
        e.hi  = !r && !s && in_win && m_lo_ph && pl;
        e.lo  = !r && !s && in_win && !m_lo_ph && ph;
        e.tag = tag;
        q.push_back(e);
        if (r) begin
            m_active = 0; m_cnt = 0; m_lo_ph = 0; m_next = 0; m_d = 0; m_t = 0;
        end else if (s) begin
            m_active = 1; m_cnt = 0; m_lo_ph = m_next; m_next = !m_next;
            m_d = d; m_t = t;
        end else if (m_active) begin
            m_cnt++;
        end
    endtask

    task automatic run(input int n, input bit ph, input bit pl,
                       input int d, input int t, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, ph, pl, d, t, tag);
    endtask

    initial begin
        // R1: reset state and idle before the first strobe
        step(1, 0, 1, 1, 0, 0, "R1_reset");
        step(1, 0, 1, 1, 0, 0, "R1_reset");
        run(5, 1, 1, 2, 3, "R1_idle_no_soc");
        // R3 R4 R5 R6: first window is high phase, delay 3, on 5
        step(0, 1, 1, 1, 3, 5, "R5_soc_first");
        run(11, 1, 1, 3, 5, "R3_R4_R6_window_hi");
        // R5 R7: second window is low phase
        step(0, 1, 1, 1, 3, 5, "R5_soc_second");
        run(11, 1, 1, 3, 5, "R7_window_lo");
        // R2 R11: retrigger mid-window
        step(0, 1, 1, 1, 2, 6, "R11_soc_blank");
        run(4, 1, 1, 2, 6, "R2_pre_retrigger");
        step(0, 1, 1, 1, 2, 6, "R11_soc_midwindow");
        run(10, 1, 1, 2, 6, "R2_after_retrigger");
        // R8: primary high gate falls mid-window (next window is high phase)
        step(0, 1, 1, 1, 1, 8, "R8_soc");
        run(4, 1, 1, 1, 8, "R8_before_fall");
        run(6, 0, 1, 1, 8, "R8_truncated");
        // R9: low-phase window with primary low gate off
        step(0, 1, 1, 0, 1, 6, "R9_soc");
        run(9, 1, 0, 1, 6, "R9_suppressed");
        // R10: config changes mid-window ignored
        step(0, 1, 1, 1, 2, 3, "R10_soc");
        run(3, 1, 1, 0, 9, "R10_changed_cfg");
        run(6, 1, 1, 7, 1, "R10_changed_cfg");
        // R3: zero delay
        step(0, 1, 1, 1, 0, 2, "R3_soc_zero_delay");
        run(5, 1, 1, 0, 2, "R3_zero_delay");
        // R4: zero on-time
        step(0, 1, 1, 1, 1, 0, "R4_soc_zero_on");
        run(5, 1, 1, 1, 0, "R4_zero_on");
        // R1 R5: reset mid-sequence brings back the high phase
        step(0, 1, 1, 1, 1, 4, "R1_soc_before_reset");
        run(2, 1, 1, 1, 4, "R1_window");
        step(1, 0, 1, 1, 1, 4, "R1_reset_mid");
        run(3, 1, 1, 1, 4, "R1_idle_after_reset");
        step(0, 1, 1, 1, 1, 4, "R5_soc_after_reset");
        run(7, 1, 1, 1, 4, "R5_high_after_reset");
        @(negedge clk);
        monitor_pop();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule